// File: doc/BRIEF.md
# Fine-Tuned Oscillator Complex Down-Mixer

This block is the first stage of a single-sideband digital down converter. Real signed 8-bit samples come from a converter running at exactly 2^30 samples per second. They arrive in parallel lanes, two per fabric clock by default. Lane 0 carries the earlier sample in time. A 30-bit phase accumulator forms the local oscillator. Because the sample rate is an exact power of two, one least-significant bit of the tuning word is exactly 1 Hz.

For each lane, the top eight phase bits select a quantized cosine and sine value. The sample is multiplied by each value in a multiplier built only from adder-generated lookup tables, with no hard multipliers. The block outputs the in-phase product (sample times cosine) and the quadrature product (minus sample times sine) at the input rate, so that a later stage can pick the wanted sideband.

The tuning word is loaded through a write strobe. A separate clear input sets the phase to zero, for example on a once-per-second timing edge. Filtering and decimation follow in later stages.

There is no controlling state machine. The datapath runs every cycle, and the only sequencing is a register load on the write strobe and the clear. A clear takes priority over the normal advance.

Top module: `nco_iq_mixer`

## Requirements
- R1: While `rst_n` is low and after it is released, `out_valid` is 0 and every `out_i`/`out_q` lane is 0 until the first valid sample is registered. The accumulator and the tuning word both reset to 0.
- R2: In a cycle where the accumulator holds P and the active tuning word is F, lane k uses phase P + k·F (mod 2^30). At each clock the accumulator advances by LANES·F (mod 2^30).
- R3: The lookup index is phase bits [29:22]. The cosine value is round(127·cos(2π·idx/256)) and the sine value is round(127·sin(2π·idx/256)), with halves rounded away from zero. Lane k of `out_i` is sample·cos and lane k of `out_q` is −sample·sin, each signed 16-bit, packed with lane k at bits [16k+15:16k].
- R4: Data and `out_valid` come out one clock after the sample. When `in_valid` is high, `out_valid` is high on the next cycle; when it is low, `out_valid` is low on the next cycle.
- R5: While `in_valid` is low, `out_i` and `out_q` keep their previous values. The accumulator keeps advancing.
- R6: A word presented with `tune_we` high becomes the active F from the next clock on. The advance made at the writing edge still uses the old word.
- R7: When `phase_clr` is high at a clock edge, the accumulator is 0 after that edge, whatever the advance would have been.
- R8: With F = 0 and a cleared phase, every lane gives `out_i` = 127·sample and `out_q` = 0.
- R9: Full-scale samples −128 and +127 produce exact products (for example −16256 and +16129) without wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock, one lane group per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| tune_we | input | 1 | Loads `tune_word` into the active tuning register |
| tune_word | input | 30 | Tuning word, 1 Hz per LSB |
| phase_clr | input | 1 | Sets the phase accumulator to zero |
| in_valid | input | 1 | Qualifies `in_samp` |
| in_samp | input | 16 | Two signed 8-bit samples, lane 0 (earlier) in bits [7:0] |
| out_valid | output | 1 | Qualifies `out_i`/`out_q`, one cycle after `in_valid` |
| out_i | output | 32 | Two signed 16-bit in-phase products, lane 0 low |
| out_q | output | 32 | Two signed 16-bit quadrature products, lane 0 low |

## Verification
The mixer is driven with a zero tuning word, so both lanes must give a DC scaling of the sample. A word of 1 keeps the index at 0 for millions of samples; here any lane-offset or step error in the low bits shows only as a wrong accumulator later, which the clear and reload scenarios reveal. A word of 2^29 puts the two lanes exactly half a cycle apart, so a swapped lane or a missing per-lane offset flips the sign of the in-phase product. An arbitrary word sweeps the index through all four quadrants, testing the quarter-wave folding and the sign of the quadrature output. Further runs check that a tuning write does not act a cycle early or late, that a clear wins over the advance, that outputs hold while invalid, and that full-scale samples give exact products.

// File: rtl/nco_pkg.sv
package nco_pkg;

    // Quarter-wave table: round(127*sin(2*pi*r/256)) for r = 0..63
    function automatic logic [6:0] quarter_sin(input logic [5:0] r);
        logic [6:0] v;
        unique case (r)
            6'd0:  v = 7'd0;   6'd1:  v = 7'd3;   6'd2:  v = 7'd6;   6'd3:  v = 7'd9;
            6'd4:  v = 7'd12;  6'd5:  v = 7'd16;  6'd6:  v = 7'd19;  6'd7:  v = 7'd22;
            6'd8:  v = 7'd25;  6'd9:  v = 7'd28;  6'd10: v = 7'd31;  6'd11: v = 7'd34;
            6'd12: v = 7'd37;  6'd13: v = 7'd40;  6'd14: v = 7'd43;  6'd15: v = 7'd46;
            6'd16: v = 7'd49;  6'd17: v = 7'd51;  6'd18: v = 7'd54;  6'd19: v = 7'd57;
            6'd20: v = 7'd60;  6'd21: v = 7'd63;  6'd22: v = 7'd65;  6'd23: v = 7'd68;
            6'd24: v = 7'd71;  6'd25: v = 7'd73;  6'd26: v = 7'd76;  6'd27: v = 7'd78;
            6'd28: v = 7'd81;  6'd29: v = 7'd83;  6'd30: v = 7'd85;  6'd31: v = 7'd88;
            6'd32: v = 7'd90;  6'd33: v = 7'd92;  6'd34: v = 7'd94;  6'd35: v = 7'd96;
            6'd36: v = 7'd98;  6'd37: v = 7'd100; 6'd38: v = 7'd102; 6'd39: v = 7'd104;
            6'd40: v = 7'd106; 6'd41: v = 7'd107; 6'd42: v = 7'd109; 6'd43: v = 7'd111;
            6'd44: v = 7'd112; 6'd45: v = 7'd113; 6'd46: v = 7'd115; 6'd47: v = 7'd116;
            6'd48: v = 7'd117; 6'd49: v = 7'd118; 6'd50: v = 7'd120; 6'd51: v = 7'd121;
            6'd52: v = 7'd122; 6'd53: v = 7'd122; 6'd54: v = 7'd123; 6'd55: v = 7'd124;
            6'd56: v = 7'd125; 6'd57: v = 7'd125; 6'd58: v = 7'd126; 6'd59: v = 7'd126;
            6'd60: v = 7'd126; 6'd61: v = 7'd127; 6'd62: v = 7'd127; 6'd63: v = 7'd127;
            default: v = 7'd0;
        endcase
        return v;
    endfunction

    // Full-circle signed sine from an 8-bit index by quadrant folding
    function automatic logic signed [7:0] full_sin(input logic [7:0] idx);
        logic [5:0] r;
        logic [6:0] mag;
        r = idx[5:0];
        if (idx[6]) mag = (r == 6'd0) ? 7'd127 : quarter_sin(6'(7'd64 - {1'b0, r}));
        else        mag = quarter_sin(r);
        return idx[7] ? -$signed({1'b0, mag}) : $signed({1'b0, mag});
    endfunction

endpackage

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
    parameter int PHASE_W = 30,
    parameter int LANES   = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         tune_we,
    input  logic [PHASE_W-1:0]           tune_word,
    input  logic                         phase_clr,
    output logic [LANES-1:0][PHASE_W-1:0] lane_phase
);
    logic [PHASE_W-1:0] acc_q;
    logic [PHASE_W-1:0] tw_q;
    logic [LANES:0][PHASE_W-1:0] chain;

    // Lane k phase = acc + k*F, built as an adder chain; chain[LANES] is the next base
    assign chain[0] = acc_q;
    for (genvar k = 1; k <= LANES; k++) begin : g_chain
        assign chain[k] = chain[k-1] + tw_q;
    end
    for (genvar k = 0; k < LANES; k++) begin : g_out
        assign lane_phase[k] = chain[k];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            tw_q  <= '0;
        end else begin
            if (phase_clr) acc_q <= '0;
            else           acc_q <= chain[LANES];
            if (tune_we)   tw_q  <= tune_word;
        end
    end

    assert_clear_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        phase_clr |=> (acc_q == '0));

    assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !phase_clr |=> (acc_q == PHASE_W'($past(acc_q) + PHASE_W'(LANES) * $past(tw_q))));

    assert_tune_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tune_we |=> (tw_q == $past(tune_word)));
endmodule

// File: rtl/nco_sincos.sv
module nco_sincos #(
    parameter int PHASE_W = 30,
    parameter int IDX_W   = 8
) (
    input  logic [PHASE_W-1:0] phase,
    output logic signed [7:0]  cos_v,
    output logic signed [7:0]  sin_v
);
    import nco_pkg::*;
    logic [IDX_W-1:0] idx;
    localparam logic [IDX_W-1:0] QUARTER = IDX_W'(1 << (IDX_W - 2));

    assign idx   = phase[PHASE_W-1 -: IDX_W];
    assign sin_v = full_sin(idx);
    assign cos_v = full_sin(idx + QUARTER);
endmodule

// File: rtl/nco_lut_mult.sv
module nco_lut_mult #(
    parameter int SAMP_W = 8,
    parameter int COEF_W = 8
) (
    input  logic signed [SAMP_W-1:0]        samp,
    input  logic signed [COEF_W-1:0]        coef,
    output logic signed [SAMP_W+COEF_W-1:0] prod
);
    localparam int NIB   = SAMP_W / 2;
    localparam int ENT   = 1 << NIB;
    localparam int PW    = SAMP_W + COEF_W;

    // Table of multiples j*coef, filled by an adder chain
    logic signed [ENT-1:0][PW-1:0] mult_tab;
    assign mult_tab[0] = '0;
    for (genvar j = 1; j < ENT; j++) begin : g_tab
        assign mult_tab[j] = mult_tab[j-1] + PW'(coef);
    end

    logic signed [PW-1:0] hi_part;
    logic signed [PW-1:0] lo_part;
    logic signed [PW-1:0] coef_ext;

    assign coef_ext = PW'(coef);
    always_comb begin
        lo_part = mult_tab[samp[NIB-1:0]];
        hi_part = mult_tab[samp[SAMP_W-1:NIB]];
        // Upper nibble is signed: a set sign bit means subtract ENT*coef
        if (samp[SAMP_W-1]) hi_part = hi_part - (coef_ext <<< NIB);
        prod = (hi_part <<< NIB) + lo_part;
    end
endmodule

// File: rtl/nco_iq_mixer.sv
module nco_iq_mixer #(
    parameter int PHASE_W = 30,
    parameter int SAMP_W  = 8,
    parameter int LANES   = 2,
    parameter int OUT_W   = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      tune_we,
    input  logic [PHASE_W-1:0]        tune_word,
    input  logic                      phase_clr,
    input  logic                      in_valid,
    input  logic [LANES*SAMP_W-1:0]   in_samp,
    output logic                      out_valid,
    output logic [LANES*OUT_W-1:0]    out_i,
    output logic [LANES*OUT_W-1:0]    out_q
);
    localparam int COEF_W = 8;
    localparam int PW     = SAMP_W + COEF_W;

    logic [LANES-1:0][PHASE_W-1:0] lane_phase;
    logic [LANES*OUT_W-1:0] i_next, q_next;

    nco_phase_acc #(.PHASE_W(PHASE_W), .LANES(LANES)) u_acc (
        .clk        (clk),
        .rst_n      (rst_n),
        .tune_we    (tune_we),
        .tune_word  (tune_word),
        .phase_clr  (phase_clr),
        .lane_phase (lane_phase)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic signed [COEF_W-1:0] c_v, s_v;
        logic signed [PW-1:0]     pi, ps;
        logic signed [SAMP_W-1:0] smp;

        assign smp = in_samp[k*SAMP_W +: SAMP_W];

        nco_sincos #(.PHASE_W(PHASE_W), .IDX_W(8)) u_sc (
            .phase (lane_phase[k]),
            .cos_v (c_v),
            .sin_v (s_v)
        );
        nco_lut_mult #(.SAMP_W(SAMP_W), .COEF_W(COEF_W)) u_mi (
            .samp (smp), .coef (c_v), .prod (pi)
        );
        nco_lut_mult #(.SAMP_W(SAMP_W), .COEF_W(COEF_W)) u_mq (
            .samp (smp), .coef (s_v), .prod (ps)
        );
        assign i_next[k*OUT_W +: OUT_W] = OUT_W'(pi);
        assign q_next[k*OUT_W +: OUT_W] = OUT_W'(-ps);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_i     <= '0;
            out_q     <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_i <= i_next;
                out_q <= q_next;
            end
        end
    end

    assert_valid_on_R4: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_valid_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_i) && $stable(out_q)));
endmodule

// File: tb/nco_iq_mixer_tb.sv
`timescale 1ns/1ps
module nco_iq_mixer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tune_we = 1'b0;
    logic [29:0] tune_word = '0;
    logic        phase_clr = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_samp = '0;
    logic        out_valid;
    logic [31:0] out_i, out_q;

    int checks = 0;
    int fails  = 0;
    logic [29:0] m_acc = '0;
    logic [29:0] m_tw  = '0;

    always #2.5 clk = ~clk;

    nco_iq_mixer u_dut (
        .clk(clk), .rst_n(rst_n), .tune_we(tune_we), .tune_word(tune_word),
        .phase_clr(phase_clr), .in_valid(in_valid), .in_samp(in_samp),
        .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
    );

    function automatic int qtrig(input int idx, input bit use_cos);
        real a, v;
        a = 2.0 * 3.14159265358979323846 * idx / 256.0;
        v = 127.0 * (use_cos ? $cos(a) : $sin(a));
        if (v >= 0.0) return $rtoi(v + 0.5);
        return -$rtoi(-v + 0.5);
    endfunction

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // One clock: drive at negedge, check after the edge, then advance the model
    task automatic step(input logic [7:0] s0, input logic [7:0] s1, input bit v,
                        input bit we, input logic [29:0] w, input bit clr, input string tag);
        int exp_i[2], exp_q[2];
        logic [31:0] prev_i, prev_q;
        logic [29:0] ph;
        int s;
        @(negedge clk);
        prev_i = out_i; prev_q = out_q;
        in_samp = {s1, s0}; in_valid = v; tune_we = we; tune_word = w; phase_clr = clr;
        for (int k = 0; k < 2; k++) begin
            ph = m_acc + 30'(k) * m_tw;
            s  = (k == 0) ? int'($signed(s0)) : int'($signed(s1));
            exp_i[k] = s * qtrig(int'(ph[29:22]), 1'b1);
            exp_q[k] = -(s * qtrig(int'(ph[29:22]), 1'b0));
        end
        @(posedge clk);
        #1;
        check(tag, "out_valid", int'(out_valid), int'(v));
        for (int k = 0; k < 2; k++) begin
            if (v) begin
                check(tag, "I", int'($signed(out_i[16*k +: 16])), exp_i[k]);
                check(tag, "Q", int'($signed(out_q[16*k +: 16])), exp_q[k]);
            end else begin
                check(tag, "I hold", int'($signed(out_i[16*k +: 16])), int'($signed(prev_i[16*k +: 16])));
                check(tag, "Q hold", int'($signed(out_q[16*k +: 16])), int'($signed(prev_q[16*k +: 16])));
            end
        end
        m_acc = clr ? 30'd0 : m_acc + 30'd2 * m_tw;
        if (we) m_tw = w;
        tune_we = 1'b0; phase_clr = 1'b0;
    endtask

    task automatic load_word(input logic [29:0] w, input string tag);
        step(8'd0, 8'd0, 1'b0, 1'b1, w, 1'b1, tag);
    endtask

    task automatic run_pattern(input int n, input int seed, input string tag);
        for (int t = 0; t < n; t++)
            step(8'(t * 37 + seed), 8'(t * 91 + 3 * seed), 1'b1, 1'b0, '0, 1'b0, tag);
    endtask

    task automatic test_reset();
        @(negedge clk);
        check("R1", "valid in reset", int'(out_valid), 0);
        check("R1", "I in reset", int'(out_i), 0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check("R1", "valid after reset", int'(out_valid), 0);
        check("R1", "Q after reset", int'(out_q), 0);
    endtask

    task automatic test_dc();   // R8: F = 0
        load_word(30'd0, "R8");
        run_pattern(6, 11, "R8");
        step(8'd100, 8'h9C, 1'b1, 1'b0, '0, 1'b0, "R8");
        check("R8", "I lane0 dc", int'($signed(out_i[15:0])), 12700);
    endtask

    task automatic test_slow();  // R2: F = 1 keeps index near 0
        load_word(30'd1, "R2");
        run_pattern(20, 5, "R2");
    endtask

    task automatic test_quarter(); // R2/R3: lanes half a cycle apart
        load_word(30'h2000_0000, "R2");
        run_pattern(8, 77, "R2");
        step(8'd10, 8'd10, 1'b1, 1'b0, '0, 1'b0, "R2");
        check("R2", "lane1 opposite sign", int'($signed(out_i[31:16])), -1270);
    endtask

    task automatic test_random(); // R3: sweep all quadrants
        load_word(30'h0A5C_3E17, "R3");
        run_pattern(300, 29, "R3");
    endtask

    task automatic test_hold();   // R4, R5
        run_pattern(3, 1, "R4");
        for (int t = 0; t < 4; t++)
            step(8'(t + 50), 8'(t + 9), 1'b0, 1'b0, '0, 1'b0, "R5");
        run_pattern(3, 2, "R4");
    endtask

    task automatic test_tune_timing(); // R6
        load_word(30'h0100_0000, "R6");
        run_pattern(3, 4, "R6");
        step(8'd60, 8'd60, 1'b1, 1'b1, 30'h0500_0000, 1'b0, "R6");
        run_pattern(5, 8, "R6");
    endtask

    task automatic test_clear();  // R7
        run_pattern(4, 6, "R7");
        step(8'd70, 8'd70, 1'b1, 1'b0, '0, 1'b1, "R7");
        step(8'd100, 8'd100, 1'b1, 1'b0, '0, 1'b0, "R7");
        check("R7", "I lane0 at phase 0", int'($signed(out_i[15:0])), 12700);
        run_pattern(4, 9, "R7");
    endtask

    task automatic test_extremes(); // R9
        load_word(30'd0, "R9");
        step(8'h80, 8'h7F, 1'b1, 1'b0, '0, 1'b0, "R9");
        check("R9", "I -128*127", int'($signed(out_i[15:0])), -16256);
        check("R9", "I 127*127", int'($signed(out_i[31:16])), 16129);
        load_word(30'h1000_0000, "R9");
        step(8'h80, 8'h80, 1'b1, 1'b0, '0, 1'b0, "R9");
        step(8'h7F, 8'h80, 1'b1, 1'b0, '0, 1'b0, "R9");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        test_reset();
        test_dc();
        test_slow();
        test_quarter();
        test_random();
        test_hold();
        test_tune_timing();
        test_clear();
        test_extremes();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule